// File: doc/BRIEF.md
# Dual-Sign-Bit Signed Adder/Subtractor

This block adds or subtracts two signed two's-complement integers of `DATA_W` bits. It is purely combinational. Inside, each operand is widened by one extra copy of its sign bit, which gives two sign positions. The full widened word goes through a single ripple adder, and any carry out of the top position is dropped. For subtraction, every bit of the widened subtrahend is inverted, both sign copies included, and a carry of one enters at the least significant position.

The two sign positions of the widened sum tell the caller how the operation ended. When they agree, the result fits in `DATA_W` bits. When they disagree, the top position says which way the true result left the range: top 0 means it went above the largest positive value, and top 1 means it went below the most negative value. The top position is therefore always the true sign of the mathematical result. The returned word is the lower sign position followed by the value bits.

Top module: `dual_sign_addsub`

## Requirements
- R1: With `sub_i` = 0, `sum_o` equals (a + b) mod 2^DATA_W, with a and b read as signed two's-complement numbers.
- R2: With `sub_i` = 1, `sum_o` equals (a - b) mod 2^DATA_W.
- R3: When the true result lies in [-2^(DATA_W-1), 2^(DATA_W-1)-1], both `ovf_pos_o` and `ovf_neg_o` are 0.
- R4: `ovf_pos_o` is 1 exactly when the true result is greater than 2^(DATA_W-1)-1. This is the sign pair 01, written upper then lower.
- R5: `ovf_neg_o` is 1 exactly when the true result is less than -2^(DATA_W-1). This is the sign pair 10.
- R6: `sign_o` is 1 exactly when the true result is negative, including when it is out of range.
- R7: `err_o` is 1 exactly when the two sign positions differ. It equals `ovf_pos_o` OR `ovf_neg_o`, and the two flags are never 1 together.
- R8: Subtracting the most negative value (bit pattern 1 followed by zeros) from zero raises `ovf_pos_o` and returns that same bit pattern on `sum_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | DATA_W | First operand, signed two's complement |
| b_i | input | DATA_W | Second operand, signed two's complement |
| sub_i | input | 1 | 0 selects a + b, 1 selects a - b |
| sum_o | output | DATA_W | Lower sign position and value bits of the widened sum |
| ovf_pos_o | output | 1 | True result above the positive maximum |
| ovf_neg_o | output | 1 | True result below the negative minimum |
| err_o | output | 1 | Sign positions disagree |
| sign_o | output | 1 | Upper sign position: true sign of the result |

## Verification
A fault in the widening step, in the inverter, in the carry chain or in the sign decode shows up at the ports in the same cycle as the operands, because the block holds no state. A wrong bit in the carry chain corrupts `sum_o` for some operand pairs. A slip in the sign decode makes `sign_o` disagree with the true sign, or reports the wrong overflow direction, on exactly the out-of-range pairs. Every operand pair at a width of four bits, in both modes, therefore exposes any such fault on the clock where that pair is applied.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

  // Sign-pair outcome; the encoding is the {upper, lower} sign pair itself.
  typedef enum logic [1:0] {
    SP_POS = 2'b00,
    SP_OVF = 2'b01,
    SP_UNF = 2'b10,
    SP_NEG = 2'b11
  } sign_pair_e;

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

endpackage

// File: rtl/dsb_operand_prep.sv
module dsb_operand_prep #(
  parameter int DATA_W = 8,
  localparam int EXT_W = DATA_W + 1
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [EXT_W-1:0]  a_ext_o,
  output logic [EXT_W-1:0]  b_ext_o,
  output logic              cin_o
);

  function automatic logic [EXT_W-1:0] widen(input logic [DATA_W-1:0] v);
    return {v[DATA_W-1], v};
  endfunction

  // Subtraction: invert the whole widened word (both sign copies), +1 via carry-in.
  function automatic logic [EXT_W-1:0] cond_invert(input logic [EXT_W-1:0] v,
                                                   input logic inv);
    return inv ? ~v : v;
  endfunction

  assign a_ext_o = widen(a_i);
  assign b_ext_o = cond_invert(widen(b_i), sub_i);
  assign cin_o   = sub_i;

endmodule

// File: rtl/dsb_ripple_adder.sv
module dsb_ripple_adder
  import dsb_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] s_o
);

  // Carry into each position; the carry out of the top position is dropped.
  logic [WIDTH-1:0] carry;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign s_o[i] = fa_sum(x_i[i], y_i[i], carry[i]);
    if (i < WIDTH - 1) begin : g_carry
      assign carry[i+1] = fa_carry(x_i[i], y_i[i], carry[i]);
    end
  end

endmodule

// File: rtl/dsb_sign_classifier.sv
module dsb_sign_classifier
  import dsb_pkg::*;
(
  input  logic       upper_i,
  input  logic       lower_i,
  output logic       ovf_pos_o,
  output logic       ovf_neg_o,
  output logic       err_o,
  output logic       sign_o
);

  sign_pair_e pair;

  assign pair = sign_pair_e'({upper_i, lower_i});

  always_comb begin
    ovf_pos_o = 1'b0;
    ovf_neg_o = 1'b0;
    unique case (pair)
      SP_OVF:  ovf_pos_o = 1'b1;
      SP_UNF:  ovf_neg_o = 1'b1;
      default: ;
    endcase
  end

  assign err_o  = upper_i ^ lower_i;
  assign sign_o = upper_i;

endmodule

// File: rtl/dual_sign_addsub.sv
module dual_sign_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_pos_o,
  output logic              ovf_neg_o,
  output logic              err_o,
  output logic              sign_o
);

  localparam int EXT_W = DATA_W + 1;

  // Named internal events, visible to the bound checker.
  logic [EXT_W-1:0] a_ext;
  logic [EXT_W-1:0] b_ext;
  logic             cin;
  logic [EXT_W-1:0] sum_ext;

  dsb_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (sub_i),
    .a_ext_o (a_ext),
    .b_ext_o (b_ext),
    .cin_o   (cin)
  );

  dsb_ripple_adder #(.WIDTH(EXT_W)) u_add (
    .x_i   (a_ext),
    .y_i   (b_ext),
    .cin_i (cin),
    .s_o   (sum_ext)
  );

  dsb_sign_classifier u_cls (
    .upper_i   (sum_ext[EXT_W-1]),
    .lower_i   (sum_ext[DATA_W-1]),
    .ovf_pos_o (ovf_pos_o),
    .ovf_neg_o (ovf_neg_o),
    .err_o     (err_o),
    .sign_o    (sign_o)
  );

  assign sum_o = sum_ext[DATA_W-1:0];

endmodule

// File: rtl/dsb_checker.sv
module dsb_checker #(
  parameter int DATA_W = 8
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              sub_i,
  input logic [DATA_W-1:0] sum_o,
  input logic              ovf_pos_o,
  input logic              ovf_neg_o,
  input logic              err_o,
  input logic              sign_o
);

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  always_comb begin
    // R7
    flags_exclusive_chk: assert (!(ovf_pos_o && ovf_neg_o))
      else $error("both overflow directions set");
    // R7
    err_matches_flags_chk: assert (err_o == (ovf_pos_o || ovf_neg_o))
      else $error("error flag disagrees with direction flags");
    // R3
    no_overflow_chk: assert (err_o || (sign_o == sum_o[DATA_W-1]))
      else $error("in-range result sign differs from true sign");
    // R4
    pos_overflow_chk: assert (!ovf_pos_o || (!sign_o && sum_o[DATA_W-1]))
      else $error("positive overflow without wrapped negative word");
    // R5
    neg_underflow_chk: assert (!ovf_neg_o || (sign_o && !sum_o[DATA_W-1]))
      else $error("negative underflow without wrapped positive word");
    // R8
    min_negate_chk: assert (!(sub_i && a_i == '0 && b_i == MOST_NEG) ||
                            (ovf_pos_o && sum_o == MOST_NEG))
      else $error("negating most negative value missed overflow");
    // R1
    add_zero_chk: assert (sub_i || b_i != '0 || (sum_o == a_i && !err_o))
      else $error("adding zero changed operand");
  end

endmodule

bind dual_sign_addsub dsb_checker #(.DATA_W(DATA_W)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .sub_i     (sub_i),
  .sum_o     (sum_o),
  .ovf_pos_o (ovf_pos_o),
  .ovf_neg_o (ovf_neg_o),
  .err_o     (err_o),
  .sign_o    (sign_o)
);

// File: tb/dual_sign_addsub_test.sv
module dual_sign_addsub_test;

  localparam int W      = 4;
  localparam int MAXV   = (1 << (W - 1)) - 1;
  localparam int MINV   = -(1 << (W - 1));
  localparam int MASK   = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         sub_i = 1'b0;
  logic [W-1:0] sum_o;
  logic         ovf_pos_o, ovf_neg_o, err_o, sign_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  typedef struct {
    int  sum;
    bit  pos;
    bit  neg;
    bit  sgn;
    bit  sub;
  } expect_t;

  expect_t pending[$];

  always #2.5 clk = ~clk;

  dual_sign_addsub #(.DATA_W(W)) uut (
    .a_i(a_i), .b_i(b_i), .sub_i(sub_i), .sum_o(sum_o),
    .ovf_pos_o(ovf_pos_o), .ovf_neg_o(ovf_neg_o),
    .err_o(err_o), .sign_o(sign_o)
  );

  task automatic check(input string req, input int act, input int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d sub=%0d actual=%0d expected=%0d",
               req, a_i, b_i, sub_i, act, exp_v);
    end
  endtask

  task automatic apply(input int x, input int y, input bit s);
    int     t;
    expect_t e;
    @(posedge clk);
    #1;
    a_i   = W'(x);
    b_i   = W'(y);
    sub_i = s;
    t     = s ? x - y : x + y;
    e.sum = t & MASK;
    e.pos = (t > MAXV);
    e.neg = (t < MINV);
    e.sgn = (t < 0);
    e.sub = s;
    pending.push_back(e);
  endtask

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && pending.size() > 0) begin
      expect_t e;
      e = pending.pop_front();
      check(e.sub ? "R2" : "R1", int'(sum_o), e.sum);
      check((e.pos || e.neg) ? "R4" : "R3", int'(ovf_pos_o), int'(e.pos));
      check((e.pos || e.neg) ? "R5" : "R3", int'(ovf_neg_o), int'(e.neg));
      check("R6", int'(sign_o), int'(e.sgn));
      check("R7", int'(err_o), int'(e.pos | e.neg));
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: zero operands give an all-zero, flag-free output.
    check("R1", int'(sum_o), 0);
    check("R3", int'(err_o), 0);
    rst_n = 1'b1;

    // Exhaustive sweep: every operand pair, both modes.
    for (int s = 0; s < 2; s++)
      for (int x = MINV; x <= MAXV; x++)
        for (int y = MINV; y <= MAXV; y++)
          apply(x, y, bit'(s));

    // R8: 0 - most negative value.
    apply(0, MINV, 1'b1);
    @(negedge clk);
    #1;
    check("R8", int'(ovf_pos_o), 1);
    check("R8", int'(sum_o), MINV & MASK);
    @(posedge clk);
    @(negedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule